// File: doc/BRIEF.md
# Indexed Vector Shuffle Engine

This block moves elements between logical vectors held in a wide vector register file, in either of two indexed directions. A gather fills a destination vector by looking up source elements through an index vector; a scatter sends each source element to the destination position named by the matching index element. Every register holds `LANES` elements. A logical vector that starts at register `h` keeps its element `e` in register `h + e / LANES`, lane `e % LANES`. Register heads are 13 bits wide and add modulo 2^13.

A command names the direction, the three register heads, an active length taken from a scalar operand, and a second length (the span) for the vector on the far side of the index. The two lengths are independent and need not be multiples of the lane count. The engine walks the destination one register-wide beat at a time. For each destination beat it sweeps every source beat through a crossbar with one small selector per lane, gathers the result in a per-lane accumulator, and writes the beat back with per-lane write enables. A start/busy/done handshake frames each command.

The two read ports are combinational: the register file returns a row in the same cycle its address is presented.

Top module: `vshuf_engine`

## Requirements
- R1: With `op_i`=0 (gather), each destination element i in 0..avl-1 receives data element idx[i], where idx is the index vector at `vs2_head_i` and data is the vector at `vs1_head_i`. Elements of every vector follow the register/lane layout above.
- R2: In a gather, an index value at or above `span_i` yields zero for that destination element. A span of zero therefore writes zeros to all avl elements.
- R3: In a gather, destination elements at positions avl and above keep their previous contents, including the unused lanes of a partly filled final beat.
- R4: With `op_i`=1 (scatter), for each i in 0..avl-1, destination element idx[i] receives data element i. Destination elements that no index targets keep their previous contents.
- R5: In a scatter, an index value at or above `span_i` is dropped and writes nothing.
- R6: When several scatter elements name the same destination position, the one with the highest i wins. This holds whether the colliding elements share a beat or lie in different beats.
- R7: avl and span are arbitrary values up to 2^LEN_W-1, independent of each other and of the lane count. Commands that span several beats complete without any outside involvement.
- R8: A start seen while idle is accepted, and `busy_o` is high in the next cycle. `done_o` is high for exactly one cycle at the end of the command, and `busy_o` is low in the cycle after it.
- R9: A start asserted while `busy_o` is high is ignored. It does not change the running command and does not begin another.
- R10: A gather with avl=0, or a scatter with span=0, writes nothing and still completes with a done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Command request, accepted only while idle |
| op_i | input | 1 | 0 = gather, 1 = scatter |
| vd_head_i | input | HEAD_W | Destination vector head register |
| vs1_head_i | input | HEAD_W | Data vector head register |
| vs2_head_i | input | HEAD_W | Index vector head register |
| avl_i | input | LEN_W | Active length from the scalar operand |
| span_i | input | LEN_W | Length of the gather source or of the scatter destination |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_data_addr_o | output | HEAD_W | Register address on the data read port |
| rd_data_i | input | LANES*EW | Data row, lane k at bits k*EW |
| rd_idx_addr_o | output | HEAD_W | Register address on the index read port |
| rd_idx_i | input | LANES*EW | Index row, lane k at bits k*EW |
| wr_valid_o | output | 1 | Write of one destination row |
| wr_addr_o | output | HEAD_W | Destination register address |
| wr_data_o | output | LANES*EW | Destination row |
| wr_lane_en_o | output | LANES | Per-lane write enable |

## Verification
Within a single scatter beat, two lanes can target the same destination position in the same cycle, and the lane selector has to settle the collision in that cycle. This happens in addition to collisions between beats, which are settled by overwriting the accumulator. The bench sets up a directed case in which every index names one position, and random scatters whose index range is smaller than the active length, which produces both kinds of collision. The final register file is compared with a reference model that applies the elements in ascending i, so the last writer wins. A wrong priority direction, or a lost carry-over between beats, shows up as a wrong value at a colliding position.

// File: rtl/vshuf_pkg.sv
package vshuf_pkg;

   typedef enum logic {
      OP_GATHER  = 1'b0,
      OP_SCATTER = 1'b1
   } vshuf_op_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SCAN  = 2'd1,
      ST_WRITE = 2'd2,
      ST_FIN   = 2'd3
   } vshuf_state_e;

endpackage

// File: rtl/vshuf_seq.sv
module vshuf_seq
   import vshuf_pkg::*;
#(
   parameter int LANES  = 64,
   parameter int HEAD_W = 13,
   parameter int LEN_W  = 16,
   localparam int LANE_W = $clog2(LANES),
   localparam int BEAT_W = LEN_W + 1 - LANE_W
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic              op_i,
   input  logic [HEAD_W-1:0] vd_head_i,
   input  logic [HEAD_W-1:0] vs1_head_i,
   input  logic [HEAD_W-1:0] vs2_head_i,
   input  logic [LEN_W-1:0]  avl_i,
   input  logic [LEN_W-1:0]  span_i,
   output logic              busy_o,
   output logic              done_o,
   output vshuf_op_e         op_o,
   output logic [LEN_W-1:0]  avl_o,
   output logic [LEN_W-1:0]  span_o,
   output logic [BEAT_W-1:0] dbeat_o,
   output logic [BEAT_W-1:0] sbeat_o,
   output logic              scan_o,
   output logic              first_o,
   output logic              wr_o,
   output logic [HEAD_W-1:0] rd_data_addr_o,
   output logic [HEAD_W-1:0] rd_idx_addr_o,
   output logic [HEAD_W-1:0] wr_addr_o
);

   vshuf_state_e      state_q;
   vshuf_op_e         op_q;
   logic [HEAD_W-1:0] vd_q, vs1_q, vs2_q;
   logic [LEN_W-1:0]  avl_q, span_q;
   logic [BEAT_W-1:0] nd_q, ns_q, d_q, s_q;

   // number of LANES-wide beats that cover len elements
   function automatic logic [BEAT_W-1:0] beats_of(input logic [LEN_W-1:0] len);
      logic [LEN_W:0] sum;
      sum = {1'b0, len} + (LEN_W+1)'(LANES - 1);
      return BEAT_W'(sum >> LANE_W);
   endfunction

   logic [BEAT_W-1:0] outer_n, inner_n;
   always_comb begin
      if (vshuf_op_e'(op_i) == OP_GATHER) begin
         outer_n = beats_of(avl_i);
         inner_n = beats_of(span_i);
      end else begin
         outer_n = beats_of(span_i);
         inner_n = beats_of(avl_i);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         op_q    <= OP_GATHER;
         vd_q    <= '0;
         vs1_q   <= '0;
         vs2_q   <= '0;
         avl_q   <= '0;
         span_q  <= '0;
         nd_q    <= '0;
         ns_q    <= '0;
         d_q     <= '0;
         s_q     <= '0;
      end else begin
         unique case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  op_q   <= vshuf_op_e'(op_i);
                  vd_q   <= vd_head_i;
                  vs1_q  <= vs1_head_i;
                  vs2_q  <= vs2_head_i;
                  avl_q  <= avl_i;
                  span_q <= span_i;
                  nd_q   <= outer_n;
                  ns_q   <= (inner_n == '0) ? BEAT_W'(1) : inner_n;
                  d_q    <= '0;
                  s_q    <= '0;
                  state_q <= (outer_n == '0) ? ST_FIN : ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (s_q == ns_q - BEAT_W'(1)) state_q <= ST_WRITE;
               else                         s_q <= s_q + BEAT_W'(1);
            end
            ST_WRITE: begin
               if (d_q == nd_q - BEAT_W'(1)) begin
                  state_q <= ST_FIN;
               end else begin
                  d_q     <= d_q + BEAT_W'(1);
                  s_q     <= '0;
                  state_q <= ST_SCAN;
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o  = (state_q != ST_IDLE);
   assign done_o  = (state_q == ST_FIN);
   assign scan_o  = (state_q == ST_SCAN);
   assign first_o = (state_q == ST_SCAN) && (s_q == '0);
   assign wr_o    = (state_q == ST_WRITE);
   assign op_o    = op_q;
   assign avl_o   = avl_q;
   assign span_o  = span_q;
   assign dbeat_o = d_q;
   assign sbeat_o = s_q;

   assign rd_data_addr_o = vs1_q + HEAD_W'(s_q);
   assign rd_idx_addr_o  = (op_q == OP_GATHER) ? vs2_q + HEAD_W'(d_q) : vs2_q + HEAD_W'(s_q);
   assign wr_addr_o      = vd_q + HEAD_W'(d_q);

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !done_o); // R8
   AST_IDLE_AFTER_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |=> !busy_o); // R8
   AST_ACCEPT_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o) |=> busy_o); // R8
   AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && busy_o) |=> ($stable(avl_q) && $stable(span_q) && $stable(vd_q))); // R9

endmodule

// File: rtl/vshuf_gather_pe.sv
module vshuf_gather_pe #(
   parameter int LANES = 64,
   parameter int EW    = 16,
   parameter int LEN_W = 16,
   localparam int LANE_W = $clog2(LANES),
   localparam int BEAT_W = LEN_W + 1 - LANE_W,
   localparam int CW     = ((EW > LEN_W + 1) ? EW : LEN_W + 1) + 1
) (
   input  logic [EW-1:0]       idx_i,
   input  logic [LANES*EW-1:0] row_i,
   input  logic [BEAT_W-1:0]   sbeat_i,
   input  logic [LEN_W-1:0]    span_i,
   input  logic                lane_ok_i,
   output logic                hit_o,
   output logic [EW-1:0]       val_o
);

   logic [CW-1:0]     idx_w;
   logic [LANE_W-1:0] sel;
   logic              in_range, in_beat;

   assign idx_w    = CW'(idx_i);
   assign sel      = idx_i[LANE_W-1:0];
   assign in_range = idx_w < CW'(span_i);
   assign in_beat  = (idx_w >> LANE_W) == CW'(sbeat_i);
   assign hit_o    = lane_ok_i && in_range && in_beat;
   assign val_o    = row_i[sel*EW +: EW];

endmodule

// File: rtl/vshuf_scatter_pe.sv
module vshuf_scatter_pe #(
   parameter int LANES = 64,
   parameter int EW    = 16,
   parameter int LEN_W = 16,
   localparam int LANE_W = $clog2(LANES),
   localparam int BEAT_W = LEN_W + 1 - LANE_W,
   localparam int CW     = ((EW > LEN_W + 1) ? EW : LEN_W + 1) + 1
) (
   input  logic [LANES*EW-1:0] idx_row_i,
   input  logic [LANES*EW-1:0] row_i,
   input  logic [LEN_W:0]      target_i,
   input  logic [BEAT_W-1:0]   sbeat_i,
   input  logic [LEN_W-1:0]    avl_i,
   input  logic [LEN_W-1:0]    span_i,
   output logic                hit_o,
   output logic [EW-1:0]       val_o
);

   logic           in_span;
   logic [LEN_W:0] src_pos [LANES];

   assign in_span = target_i < {1'b0, span_i};

   // ascending scan: a later match overrides, so the highest source lane wins
   always_comb begin
      hit_o = 1'b0;
      val_o = '0;
      for (int i = 0; i < LANES; i++) begin
         src_pos[i] = {sbeat_i, LANE_W'(i)};
         if (in_span && (src_pos[i] < {1'b0, avl_i}) &&
             (CW'(idx_row_i[i*EW +: EW]) == CW'(target_i))) begin
            hit_o = 1'b1;
            val_o = row_i[i*EW +: EW];
         end
      end
   end

endmodule

// File: rtl/vshuf_engine.sv
module vshuf_engine
   import vshuf_pkg::*;
#(
   parameter int LANES  = 64,
   parameter int EW     = 16,
   parameter int HEAD_W = 13,
   parameter int LEN_W  = 16
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                start_i,
   input  logic                op_i,
   input  logic [HEAD_W-1:0]   vd_head_i,
   input  logic [HEAD_W-1:0]   vs1_head_i,
   input  logic [HEAD_W-1:0]   vs2_head_i,
   input  logic [LEN_W-1:0]    avl_i,
   input  logic [LEN_W-1:0]    span_i,
   output logic                busy_o,
   output logic                done_o,
   output logic [HEAD_W-1:0]   rd_data_addr_o,
   input  logic [LANES*EW-1:0] rd_data_i,
   output logic [HEAD_W-1:0]   rd_idx_addr_o,
   input  logic [LANES*EW-1:0] rd_idx_i,
   output logic                wr_valid_o,
   output logic [HEAD_W-1:0]   wr_addr_o,
   output logic [LANES*EW-1:0] wr_data_o,
   output logic [LANES-1:0]    wr_lane_en_o
);

   localparam int LANE_W = $clog2(LANES);
   localparam int BEAT_W = LEN_W + 1 - LANE_W;

   initial begin
      assert (LANES >= 2 && (LANES & (LANES - 1)) == 0)
         else $error("LANES must be a power of two of at least 2");
      assert (LEN_W > LANE_W) else $error("LEN_W must exceed log2(LANES)");
      assert (EW >= LANE_W) else $error("EW must hold a lane number");
      assert (HEAD_W >= 1) else $error("HEAD_W must be positive");
   end

   vshuf_op_e         op_q;
   logic [LEN_W-1:0]  avl_q, span_q;
   logic [BEAT_W-1:0] dbeat, sbeat;
   logic              scan, first, wr_phase;

   vshuf_seq #(.LANES(LANES), .HEAD_W(HEAD_W), .LEN_W(LEN_W)) seq_i (
      .clk_i, .rst_ni, .start_i, .op_i,
      .vd_head_i, .vs1_head_i, .vs2_head_i, .avl_i, .span_i,
      .busy_o, .done_o,
      .op_o(op_q), .avl_o(avl_q), .span_o(span_q),
      .dbeat_o(dbeat), .sbeat_o(sbeat),
      .scan_o(scan), .first_o(first), .wr_o(wr_phase),
      .rd_data_addr_o, .rd_idx_addr_o, .wr_addr_o
   );

   logic [LANES-1:0] acc_hit;
   logic [LANES-1:0] lane_ok;
   logic [LANES-1:0] lane_in_span;

   for (genvar j = 0; j < LANES; j++) begin : g_lane
      logic [LEN_W:0]  elem;
      logic            g_hit, s_hit;
      logic [EW-1:0]   g_val, s_val;
      logic [EW-1:0]   acc_val;

      assign elem            = {dbeat, LANE_W'(j)};
      assign lane_ok[j]      = elem < {1'b0, avl_q};
      assign lane_in_span[j] = elem < {1'b0, span_q};

      vshuf_gather_pe #(.LANES(LANES), .EW(EW), .LEN_W(LEN_W)) gpe_i (
         .idx_i(rd_idx_i[j*EW +: EW]), .row_i(rd_data_i),
         .sbeat_i(sbeat), .span_i(span_q), .lane_ok_i(lane_ok[j]),
         .hit_o(g_hit), .val_o(g_val)
      );

      vshuf_scatter_pe #(.LANES(LANES), .EW(EW), .LEN_W(LEN_W)) spe_i (
         .idx_row_i(rd_idx_i), .row_i(rd_data_i), .target_i(elem),
         .sbeat_i(sbeat), .avl_i(avl_q), .span_i(span_q),
         .hit_o(s_hit), .val_o(s_val)
      );

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            acc_val    <= '0;
            acc_hit[j] <= 1'b0;
         end else if (scan) begin
            if (op_q == OP_GATHER) begin
               if (g_hit)      acc_val <= g_val;
               else if (first) acc_val <= '0;
               acc_hit[j] <= 1'b0;
            end else begin
               if (s_hit) acc_val <= s_val;
               acc_hit[j] <= (first ? 1'b0 : acc_hit[j]) | s_hit;
            end
         end
      end

      assign wr_data_o[j*EW +: EW] = acc_val;
   end

   assign wr_valid_o   = wr_phase;
   assign wr_lane_en_o = (op_q == OP_GATHER) ? lane_ok : acc_hit;

   AST_WR_ONLY_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_valid_o |-> (busy_o && !done_o)); // R8
   AST_SCATTER_IN_SPAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_valid_o && op_q == OP_SCATTER) |-> ((wr_lane_en_o & ~lane_in_span) == '0)); // R5
   AST_NO_WRITE_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (start_i && !busy_o && !op_i && avl_i == '0) |=> (done_o && !wr_valid_o)); // R10

endmodule

// File: tb/vshuf_engine_tb_top.sv
module vshuf_engine_tb_top;

   localparam int LANES  = 64;
   localparam int EW     = 16;
   localparam int HEAD_W = 13;
   localparam int LEN_W  = 16;
   localparam int NREG   = 32;
   localparam int H_DAT  = 0;
   localparam int H_IDX  = 8;
   localparam int H_DST  = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;

   logic                start, op;
   logic [HEAD_W-1:0]   vd_head, vs1_head, vs2_head;
   logic [LEN_W-1:0]    avl, span;
   logic                busy, done;
   logic [HEAD_W-1:0]   rd_data_addr, rd_idx_addr, wr_addr;
   logic [LANES*EW-1:0] rd_data, rd_idx, wr_data;
   logic                wr_valid;
   logic [LANES-1:0]    wr_lane_en;

   logic [LANES*EW-1:0] rf   [NREG];
   logic [LANES*EW-1:0] snap [NREG];
   logic [LANES*EW-1:0] expd [NREG];

   int checks = 0;
   int fails  = 0;

   vshuf_engine #(.LANES(LANES), .EW(EW), .HEAD_W(HEAD_W), .LEN_W(LEN_W)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
      .vd_head_i(vd_head), .vs1_head_i(vs1_head), .vs2_head_i(vs2_head),
      .avl_i(avl), .span_i(span), .busy_o(busy), .done_o(done),
      .rd_data_addr_o(rd_data_addr), .rd_data_i(rd_data),
      .rd_idx_addr_o(rd_idx_addr), .rd_idx_i(rd_idx),
      .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data),
      .wr_lane_en_o(wr_lane_en)
   );

   assign rd_data = rf[rd_data_addr[4:0]];
   assign rd_idx  = rf[rd_idx_addr[4:0]];

   always @(posedge clk) begin
      if (wr_valid)
         for (int l = 0; l < LANES; l++)
            if (wr_lane_en[l]) rf[wr_addr[4:0]][l*EW +: EW] <= wr_data[l*EW +: EW];
   end

   function automatic logic [EW-1:0] sget(input int head, input int e);
      return snap[head + e / LANES][(e % LANES)*EW +: EW];
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic fill(input int idx_max);
      for (int r = 0; r < NREG; r++)
         for (int l = 0; l < LANES; l++)
            rf[r][l*EW +: EW] = (r >= H_IDX && r < H_DST) ? EW'($urandom % idx_max) : EW'($urandom);
   endtask

   // reference model, applied element by element in ascending order
   task automatic model(input logic o, input int n, input int sp);
      for (int r = 0; r < NREG; r++) begin
         snap[r] = rf[r];
         expd[r] = rf[r];
      end
      for (int i = 0; i < n; i++) begin
         int ix = int'(sget(H_IDX, i));
         if (!o) begin
            expd[H_DST + i / LANES][(i % LANES)*EW +: EW] = (ix < sp) ? sget(H_DAT, ix) : '0;
         end else if (ix < sp) begin
            expd[H_DST + ix / LANES][(ix % LANES)*EW +: EW] = sget(H_DAT, i);
         end
      end
   endtask

   task automatic run(input string req, input logic o, input int n, input int sp, input bit poke);
      int cyc;
      int bad;
      model(o, n, sp);
      @(negedge clk);
      op = o; avl = LEN_W'(n); span = LEN_W'(sp);
      vd_head = HEAD_W'(H_DST); vs1_head = HEAD_W'(H_DAT); vs2_head = HEAD_W'(H_IDX);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check({"R8 busy after start ", req}, 64'(busy), 64'd1);
      if (poke) begin
         // different command while busy: must be ignored (R9)
         op = ~o; avl = LEN_W'(5); span = LEN_W'(7); vd_head = HEAD_W'(H_DAT);
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      cyc = 0;
      while (!done && cyc < 20000) begin
         @(negedge clk);
         cyc++;
      end
      check({"R8 done seen ", req}, 64'(done), 64'd1);
      @(negedge clk);
      check({"R8 done single and idle after ", req}, {62'd0, done, busy}, 64'd0);
      if (poke) begin
         repeat (3) @(negedge clk);
         check("R9 no second command started", 64'(busy), 64'd0);
      end
      bad = 0;
      for (int r = 0; r < NREG; r++)
         for (int l = 0; l < LANES; l++)
            if (rf[r][l*EW +: EW] !== expd[r][l*EW +: EW]) begin
               if (bad == 0)
                  $display("FAIL %s reg=%0d lane=%0d actual=%0h expected=%0h",
                           req, r, l, rf[r][l*EW +: EW], expd[r][l*EW +: EW]);
               bad++;
            end
      checks++;
      if (bad != 0) fails++;
   endtask

   initial begin
      #1000000;
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      start = 1'b0; op = 1'b0; avl = '0; span = '0;
      vd_head = '0; vs1_head = '0; vs2_head = '0;
      for (int r = 0; r < NREG; r++) rf[r] = '0;
      repeat (3) @(negedge clk);
      check("R8 reset state", {61'd0, busy, done, wr_valid}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);

      fill(64);  run("R1 gather one beat", 1'b0, 64, 64, 1'b0);
      fill(160); run("R2 R3 R7 gather partial beats", 1'b0, 100, 130, 1'b0);
      fill(300); run("R1 R7 gather long source", 1'b0, 300, 257, 1'b0);
      fill(50);  run("R10 gather zero avl", 1'b0, 0, 40, 1'b0);
      fill(50);  run("R2 gather zero span", 1'b0, 70, 0, 1'b0);
      fill(64);  run("R4 R6 scatter one beat", 1'b1, 64, 64, 1'b0);
      fill(100); run("R5 R6 R7 scatter multi beat", 1'b1, 200, 90, 1'b0);
      fill(50);  run("R10 scatter zero span", 1'b1, 30, 0, 1'b0);

      // every index names position 5: highest i must win (R6)
      fill(50);
      for (int e = 0; e < 150; e++) rf[H_IDX + e / LANES][(e % LANES)*EW +: EW] = EW'(5);
      run("R6 scatter all collide", 1'b1, 150, 64, 1'b0);

      fill(80);  run("R9 gather with start while busy", 1'b0, 90, 80, 1'b1);

      for (int k = 0; k < 24; k++) begin
         int n  = int'($urandom % 400);
         int sp = int'($urandom % 400) + 1;
         logic o = 1'($urandom % 2);
         fill(sp + 20);
         run(o ? "R4 R5 R6 R7 random scatter" : "R1 R2 R3 R7 random gather", o, n, sp, 1'b0);
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule